// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit accumulator. The accumulator is held as two 32-bit halves, an upper word and a lower word, and the two halves together form one signed 64-bit number. A pipeline-control stage issues one operation per strobe. The long form multiplies the full 32-bit operands. The word form multiplies only the low 16 bits of each operand.

A saturation-mode input is sampled in the same cycle as the strobe, and it selects what happens when the sum goes out of range. With the mode off, the sum wraps in 64 bits. With the mode on, the two forms clamp in different ways:
- The long form limits the upper word in a 48-bit style: a negative sum forces the top 16 bits of the upper word to ones, and a non-negative sum keeps only the upper word's low 15 bits.
- The word form clamps to the signed 32-bit range and writes 1 into the upper word as an overflow marker.

Software or the surrounding datapath can clear both halves, or write either half, through dedicated ports. Both halves are always visible at the outputs.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero and `done` is low.
- R2: With `op_sel`=0 (long), both 32-bit operands are taken as signed, and their full 64-bit product is added to the accumulator {acc_hi, acc_lo}.
- R3: With `op_sel`=1 (word), only bits 15:0 of each operand are used, taken as signed. Bits 31:16 of the operands have no effect.
- R4: With saturation mode sampled low, both forms wrap the 64-bit sum into the two halves with no clamping.
- R5: Saturation on, long form, negative 64-bit sum: `acc_hi` is the sum's bits 63:32 with bits 31:16 forced to 1, and `acc_lo` is the sum's bits 31:0.
- R6: Saturation on, long form, non-negative sum: `acc_hi` keeps only the sum's bits 46:32 in its bits 14:0, with all higher bits zero, and `acc_lo` is the sum's bits 31:0.
- R7: Saturation on, word form, sum below -2^31: `acc_hi` becomes 1 and `acc_lo` becomes 0x80000000.
- R8: Saturation on, word form, sum above 2^31-1: `acc_hi` becomes 1 and `acc_lo` becomes 0x7FFFFFFF. A sum inside the signed 32-bit range is stored unchanged.
- R9: The accumulator updates on the clock edge that samples `op_valid`. `done` is high for exactly the one cycle that follows each accepted strobe.
- R10: `acc_clr` zeroes both halves on the next edge. It takes priority over a simultaneous operation, which is then dropped and raises no `done`.
- R11: `hi_ld` and `lo_ld` each write their half independently when neither a clear nor an operation is present. An operation in the same cycle takes priority over a load.
- R12: `sat_mode` is used only in a strobe cycle. Changes to it at any other time leave the accumulator unchanged and have no effect on later operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| sat_mode | input | 1 | Saturation enable, sampled with the strobe |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_clr | input | 1 | Clear both halves (highest priority) |
| hi_ld | input | 1 | Write upper half |
| hi_ld_data | input | 32 | Upper-half write value |
| lo_ld | input | 1 | Write lower half |
| lo_ld_data | input | 32 | Lower-half write value |
| acc_hi | output | 32 | Accumulator upper word |
| acc_lo | output | 32 | Accumulator lower word |
| done | output | 1 | One-cycle pulse after an accepted operation |

## Verification
Mixed-sign and extreme operands of the long form (the most negative value squared, the largest positive value squared) separate a signed multiply from an unsigned one, and a truncated product from a full one. Word operands with non-zero upper bits show whether those bits leak into the product. Preloaded accumulators that sit just inside or just past each clamp limit show which saturation rule is applied, and whether the marker value is written. Operations issued together with a clear or a load, and mode toggling between strobes, separate the priorities and the moment at which the mode is sampled.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int ACC_W    = 2 * WORD_W;
  localparam int KEEP_W   = HALF_W - 1;

  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;

  function automatic logic [ACC_W-1:0] prod_long(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    logic signed [ACC_W-1:0] xa;
    logic signed [ACC_W-1:0] xb;
    xa = {{WORD_W{a[WORD_W-1]}}, a};
    xb = {{WORD_W{b[WORD_W-1]}}, b};
    return xa * xb;
  endfunction

  function automatic logic [ACC_W-1:0] prod_word(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    logic signed [ACC_W-1:0] xa;
    logic signed [ACC_W-1:0] xb;
    xa = {{(ACC_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
    xb = {{(ACC_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
    return xa * xb;
  endfunction

  function automatic logic [WORD_W-1:0] clamp_long_hi(input logic [ACC_W-1:0] s);
    logic [WORD_W-1:0] hi;
    hi = s[ACC_W-1:WORD_W];
    if (s[ACC_W-1]) hi[WORD_W-1:HALF_W] = '1;
    else            hi[WORD_W-1:KEEP_W] = '0;
    return hi;
  endfunction

  function automatic logic word_over_pos(input logic [ACC_W-1:0] s);
    return !s[ACC_W-1] && (|s[ACC_W-2:WORD_W-1]);
  endfunction

  function automatic logic word_over_neg(input logic [ACC_W-1:0] s);
    return s[ACC_W-1] && !(&s[ACC_W-2:WORD_W-1]);
  endfunction

endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult
  import sat_mac_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  mac_op_e           op_kind,
  output logic [ACC_W-1:0]  product
);

  logic [ACC_W-1:0] p_long;
  logic [ACC_W-1:0] p_word;

  assign p_long  = prod_long(opa, opb);
  assign p_word  = prod_word(opa, opb);
  assign product = (op_kind == OP_WORD) ? p_word : p_long;

  always_comb begin
    if (op_kind == OP_WORD && opa[HALF_W-1:0] == '0)
      p_zero_word_r3: assert (product == '0);
  end

endmodule

// File: rtl/sat_mac_sat.sv
module sat_mac_sat
  import sat_mac_pkg::*;
(
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic [ACC_W-1:0]  product,
  input  mac_op_e           op_kind,
  input  logic              sat_en,
  output logic [WORD_W-1:0] nxt_hi,
  output logic [WORD_W-1:0] nxt_lo,
  output logic              ovf_pos,
  output logic              ovf_neg,
  output logic              sum_neg
);

  localparam logic [WORD_W-1:0] MARK_HI = WORD_W'(1);
  localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

  logic [ACC_W-1:0] sum;
  logic             clamp_long;
  logic             clamp_word;

  assign sum        = {acc_hi, acc_lo} + product;
  assign sum_neg    = sum[ACC_W-1];
  assign ovf_pos    = word_over_pos(sum);
  assign ovf_neg    = word_over_neg(sum);
  assign clamp_long = sat_en && (op_kind == OP_LONG);
  assign clamp_word = sat_en && (op_kind == OP_WORD);

  always_comb begin
    nxt_hi = sum[ACC_W-1:WORD_W];
    nxt_lo = sum[WORD_W-1:0];
    if (clamp_long) begin
      nxt_hi = clamp_long_hi(sum);
    end else if (clamp_word && ovf_pos) begin
      nxt_hi = MARK_HI;
      nxt_lo = POS_LIM;
    end else if (clamp_word && ovf_neg) begin
      nxt_hi = MARK_HI;
      nxt_lo = NEG_LIM;
    end
  end

  always_comb begin
    if (ovf_pos) p_excl_ovf_r8: assert (!ovf_neg);
    if (clamp_word && (ovf_pos || ovf_neg))
      p_word_marker_r7: assert (nxt_hi == MARK_HI);
    if (clamp_long && sum_neg)
      p_long_neg_r5: assert (&nxt_hi[WORD_W-1:HALF_W]);
    if (clamp_long && !sum_neg)
      p_long_pos_r6: assert (nxt_hi[WORD_W-1:KEEP_W] == '0);
    if (!sat_en)
      p_wrap_r4: assert ({nxt_hi, nxt_lo} == sum);
  end

endmodule

// File: rtl/sat_mac_acc.sv
module sat_mac_acc
  import sat_mac_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_fire,
  input  logic                         acc_clr,
  input  logic [1:0][WORD_W-1:0]       res,
  input  logic [1:0]                   ld_en,
  input  logic [1:0][WORD_W-1:0]       ld_data,
  output logic [1:0][WORD_W-1:0]       acc_q,
  output logic                         done
);

  localparam int N_HALF = 2;

  logic op_take;
  assign op_take = op_fire && !acc_clr;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)          acc_q[h] <= '0;
      else if (acc_clr)    acc_q[h] <= '0;
      else if (op_fire)    acc_q[h] <= res[h];
      else if (ld_en[h])   acc_q[h] <= ld_data[h];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= op_take;
  end

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q[0] == '0 && acc_q[1] == '0 && !done));

  p_done_after_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && !acc_clr) |=> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_fire && !acc_clr) |=> !done);

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_fire && !acc_clr && ld_en == 2'b00) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

  p_load_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en[1] && !op_fire && !acc_clr) |=> acc_q[1] == $past(ld_data[1]));

  p_load_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en[0] && !op_fire && !acc_clr) |=> acc_q[0] == $past(ld_data[0]));

endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_sel,
  input  logic              sat_mode,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              acc_clr,
  input  logic              hi_ld,
  input  logic [WORD_W-1:0] hi_ld_data,
  input  logic              lo_ld,
  input  logic [WORD_W-1:0] lo_ld_data,
  output logic [WORD_W-1:0] acc_hi,
  output logic [WORD_W-1:0] acc_lo,
  output logic              done
);

  mac_op_e                 op_kind;
  logic [ACC_W-1:0]        product;
  logic [WORD_W-1:0]       nxt_hi;
  logic [WORD_W-1:0]       nxt_lo;
  logic                    ovf_pos;
  logic                    ovf_neg;
  logic                    sum_neg;
  logic [1:0][WORD_W-1:0]  acc_q;
  logic [1:0][WORD_W-1:0]  res;
  logic [1:0][WORD_W-1:0]  ld_data;
  logic [1:0]              ld_en;

  assign op_kind = op_sel ? OP_WORD : OP_LONG;
  assign res     = {nxt_hi, nxt_lo};
  assign ld_data = {hi_ld_data, lo_ld_data};
  assign ld_en   = {hi_ld, lo_ld};
  assign acc_hi  = acc_q[1];
  assign acc_lo  = acc_q[0];

  sat_mac_mult u_mult (
    .opa     (opa),
    .opb     (opb),
    .op_kind (op_kind),
    .product (product)
  );

  sat_mac_sat u_sat (
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .product (product),
    .op_kind (op_kind),
    .sat_en  (sat_mode),
    .nxt_hi  (nxt_hi),
    .nxt_lo  (nxt_lo),
    .ovf_pos (ovf_pos),
    .ovf_neg (ovf_neg),
    .sum_neg (sum_neg)
  );

  sat_mac_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_fire (op_valid),
    .acc_clr (acc_clr),
    .res     (res),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .acc_q   (acc_q),
    .done    (done)
  );

  p_word_sat_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_clr && op_sel && sat_mode && ovf_pos) |=> (acc_hi == 32'd1 && acc_lo == 32'h7FFF_FFFF));

  p_long_neg_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_clr && !op_sel && sat_mode && sum_neg) |=> (acc_hi[31:16] == 16'hFFFF));

endmodule

// File: tb/sat_mac_tb.sv
module sat_mac_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic        sat_mode = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        acc_clr = 1'b0;
  logic        hi_ld = 1'b0;
  logic [31:0] hi_ld_data = '0;
  logic        lo_ld = 1'b0;
  logic [31:0] lo_ld_data = '0;
  logic [31:0] acc_hi;
  logic [31:0] acc_lo;
  logic        done;

  int n_checks = 0;
  int n_errors = 0;

  logic [63:0] m_acc = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  sat_mac u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .sat_mode(sat_mode), .opa(opa), .opb(opb), .acc_clr(acc_clr),
    .hi_ld(hi_ld), .hi_ld_data(hi_ld_data), .lo_ld(lo_ld),
    .lo_ld_data(lo_ld_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  function automatic logic [63:0] model(input bit w, input bit s,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc);
    longint p;
    longint sm;
    logic [31:0] hi;
    if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else   p = longint'($signed(a)) * longint'($signed(b));
    sm = longint'(acc) + p;
    if (s && !w) begin
      hi = sm[63:32];
      if (sm < 0) hi = hi | 32'hFFFF_0000;
      else        hi = hi & 32'h0000_7FFF;
      return {hi, sm[31:0]};
    end
    if (s && w) begin
      if (sm < -64'sd2147483648) return {32'd1, 32'h8000_0000};
      if (sm > 64'sd2147483647)  return {32'd1, 32'h7FFF_FFFF};
    end
    return sm;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input string tag, input bit w, input bit s,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_sel = w; sat_mode = s; opa = a; opb = b;
    m_acc = model(w, s, a, b, m_acc);
    exp_q.push_back(m_acc);
    tag_q.push_back(tag);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load(input bit dh, input logic [31:0] vh, input bit dl, input logic [31:0] vl);
    @(negedge clk);
    hi_ld = dh; hi_ld_data = vh; lo_ld = dl; lo_ld_data = vl;
    if (dh) m_acc[63:32] = vh;
    if (dl) m_acc[31:0]  = vl;
    @(negedge clk);
    hi_ld = 1'b0; lo_ld = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    acc_clr = 1'b1;
    m_acc = '0;
    @(negedge clk);
    acc_clr = 1'b0;
  endtask

  // monitor: pop one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", {32'd0, 31'd0, done}, 64'd0);
      end else begin
        check(tag_q.pop_front(), {acc_hi, acc_lo}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    check("R1 reset done", {63'd0, done}, 64'd0);

    // R2 long signed products, accumulated
    do_op("R2 long 3*-5", 1'b0, 1'b0, 32'd3, 32'hFFFF_FFFB);
    do_op("R2 long max*max", 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    do_op("R2 long min*min", 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000);
    @(negedge clk);
    check("R9 done single pulse", {63'd0, done}, 64'd0);

    // R3 word form ignores upper operand bits
    clear();
    check("R10 clear", {acc_hi, acc_lo}, 64'd0);
    do_op("R3 word 3*-2 upper junk", 1'b1, 1'b0, 32'hABCD_0003, 32'h1234_FFFE);
    do_op("R3 word -32768*-32768", 1'b1, 1'b0, 32'hFFFF_8000, 32'h0000_8000);

    // R4 wrap without saturation
    load(1'b1, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FFFF);
    check("R11 load both", {acc_hi, acc_lo}, 64'h7FFF_FFFF_FFFF_FFFF);
    do_op("R4 long wrap", 1'b0, 1'b0, 32'd1, 32'd1);

    // R5 negative long clamp
    load(1'b1, 32'h8000_1234, 1'b1, 32'h0000_0000);
    do_op("R5 long sat neg", 1'b0, 1'b1, 32'd0, 32'd0);
    // R6 non-negative long clamp
    load(1'b1, 32'h1234_5678, 1'b0, 32'h0);
    check("R11 load hi only", {acc_hi, acc_lo}, {32'h1234_5678, 32'd0});
    do_op("R6 long sat pos", 1'b0, 1'b1, 32'd2, 32'd3);

    // R8 word clamp high, and in-range pass-through
    load(1'b1, 32'd0, 1'b1, 32'h7FFF_FFF0);
    do_op("R8 word sat high", 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0100);
    clear();
    do_op("R8 word in range", 1'b1, 1'b1, 32'h0000_7FFF, 32'h0000_7FFF);

    // R7 word clamp low
    load(1'b1, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000);
    do_op("R7 word sat low", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1);

    // R12 sat_mode toggling without strobe has no effect
    load(1'b1, 32'd0, 1'b1, 32'h7FFF_FFF0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sat_mode = ~sat_mode;
    end
    @(negedge clk);
    sat_mode = 1'b1;
    check("R12 idle sat toggle", {acc_hi, acc_lo}, {32'd0, 32'h7FFF_FFF0});
    do_op("R12 sampled low wraps", 1'b1, 1'b0, 32'h0000_0100, 32'h0000_0100);

    // R11 op wins over simultaneous load
    @(negedge clk);
    op_valid = 1'b1; op_sel = 1'b0; sat_mode = 1'b0; opa = 32'd7; opb = 32'd6;
    hi_ld = 1'b1; hi_ld_data = 32'hDEAD_BEEF;
    m_acc = model(1'b0, 1'b0, 32'd7, 32'd6, m_acc);
    exp_q.push_back(m_acc);
    tag_q.push_back("R11 op over load");
    @(negedge clk);
    op_valid = 1'b0; hi_ld = 1'b0;

    // R10 clear beats simultaneous op, no done
    @(negedge clk);
    acc_clr = 1'b1; op_valid = 1'b1; op_sel = 1'b1; opa = 32'd5; opb = 32'd5;
    @(negedge clk);
    acc_clr = 1'b0; op_valid = 1'b0;
    m_acc = '0;
    check("R10 clear over op acc", {acc_hi, acc_lo}, 64'd0);
    check("R10 clear over op done", {63'd0, done}, 64'd0);

    repeat (3) @(negedge clk);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule